// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block is a watchdog timer that sits on a simple 32-bit register bus and counts a slow tick strobe. Software programs a timeout, arms the timer and must kick it before the timeout runs out. If it does not, the block drives a system reset pulse or raises an interrupt. Writes to the control locations take effect only when they carry the right magic key or code. A stray or runaway store therefore cannot disarm the timer, shorten it or fake a kick.

The timeout is held in units. Each unit is `UNIT_TICKS` tick strobes: 512 ticks of a 32 kHz strobe, so 64 units make one second. After power-on the timeout is the 31-second maximum. A software-reset location gives an immediate reset pulse on request. The mode bits control the following:
- the polarity of the reset output;
- whether an expiry produces a reset, an interrupt, or an interrupt followed by a reset on a second expiry;
- whether the watchdog stays armed after it has fired a reset.

Top module: `keyed_wdt`

## Requirements
- R1: After synchronous reset the watchdog is disabled and the mode reads 0. The length reads `0x0000F800` (1984 units in bits 15:5). The reset output sits at its inactive level, which is high for the default active-low polarity, and the interrupt is low.
- R2: A write to the mode location (offset 0x00) is accepted only when bits 31:24 equal 0x22. Writes with any other key leave the mode unchanged. Mode bits are:
  - bit0: enable
  - bit1: polarity (1 = active-high reset)
  - bit2: reset-on-expiry
  - bit3: interrupt-on-expiry
  - bit4: re-arm
  - bit6: two-stage
  The mode reads back these bits, with every other bit zero.
- R3: A write to the length location (offset 0x04) is accepted only when bits 4:0 equal 0x08 and the unit count in bits 15:5 is nonzero. It reads back as count<<5, with the key bits zero.
- R4: Once enabled, the watchdog expires after count × `UNIT_TICKS` tick strobes. It counts only on cycles where `tick_i` is high, and it does not count while disabled.
- R5: Writing exactly 0x1971 to the kick location (offset 0x08) restarts the countdown from the programmed length and clears a pending interrupt. Any other value written there is ignored.
- R6: An accepted length write also restarts the countdown at once from the new count.
- R7: An expiry with reset-on-expiry set and interrupt-on-expiry clear drives `wdt_rst_o` to its active level (the polarity bit) for `RST_CYC` clock cycles.
- R8: After a watchdog-caused reset pulse, the enable bit stays set if re-arm is set. Otherwise the enable bit is cleared.
- R9: With interrupt-on-expiry set, an expiry raises `irq_o`. The interrupt stays high until a kick or a disable. Without two-stage mode, no reset is ever produced by an expiry.
- R10: With two-stage mode, interrupt-on-expiry and reset-on-expiry all set, a second expiry with no kick in between produces the reset pulse and clears the interrupt.
- R11: Writing exactly 0x1209 to the software-reset location (offset 0x14) starts a reset pulse on the next edge, even when the watchdog is disabled or reset-on-expiry is clear. Other values written there are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle tick strobe (nominally 32 kHz) |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wdt_rst_o | output | 1 | System reset output at the programmed polarity |
| irq_o | output | 1 | Expiry interrupt, level |

## Verification
The assertions assume that `tick_i` and the bus inputs are synchronous to `clk` and steady across each rising edge. They also assume that each write lasts exactly one cycle, so one transfer is never seen as two. The stimulus changes every input on the falling edge and drops `bus_wr` after a single cycle. Every expiry window is timed from the edge that accepted the arming write. The stimulus never overlaps a software reset with a watchdog-caused pulse, so each pulse length can be checked on its own.

// File: rtl/kwdt_pkg.sv
// Package: shared offsets, keys and the mode field layout of the keyed watchdog.
// Assumes byte offsets fit in 8 bits; wider address buses zero-extend them.
package kwdt_pkg;
    localparam logic [7:0]  OFS_MODE   = 8'h00;
    localparam logic [7:0]  OFS_LEN    = 8'h04;
    localparam logic [7:0]  OFS_KICK   = 8'h08;
    localparam logic [7:0]  OFS_SWRST  = 8'h14;

    localparam logic [7:0]  MODE_KEY   = 8'h22;
    localparam logic [4:0]  LEN_KEY    = 5'h08;
    localparam logic [31:0] KICK_CODE  = 32'h0000_1971;
    localparam logic [31:0] SWRST_CODE = 32'h0000_1209;

    localparam int LEN_LSB = 5;

    typedef struct packed {
        logic two_stage;   // bit6
        logic rearm;       // bit4
        logic irq_en;      // bit3
        logic rst_en;      // bit2
        logic pol_hi;      // bit1
        logic en;          // bit0
    } mode_t;
endpackage

// File: rtl/kwdt_regs.sv
// Register file: decodes bus writes, checks keys and codes, holds mode and length,
// and issues kick, software-reset and reload strobes. Assumes one-cycle writes.
module kwdt_regs
    import kwdt_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int LEN_W     = 11,
    parameter int DEF_UNITS = 1984
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              clr_en_i,
    output mode_t             mode_o,
    output logic [LEN_W-1:0]  len_o,
    output logic              kick_o,
    output logic              swrst_o,
    output logic              reload_o,
    output logic [LEN_W-1:0]  reload_val_o
);
    localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFS_MODE);
    localparam logic [ADDR_W-1:0] A_LEN   = ADDR_W'(OFS_LEN);
    localparam logic [ADDR_W-1:0] A_KICK  = ADDR_W'(OFS_KICK);
    localparam logic [ADDR_W-1:0] A_SWRST = ADDR_W'(OFS_SWRST);

    mode_t            mode_q;
    mode_t            mode_wr;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] len_field;
    logic             mode_ok;
    logic             len_ok;
    logic             en_start;

    // Purpose: key and code checks for every control location.
    always_comb begin
        len_field = bus_wdata[LEN_LSB +: LEN_W];
        mode_ok   = bus_wr && (bus_addr == A_MODE) && (bus_wdata[31:24] == MODE_KEY);
        len_ok    = bus_wr && (bus_addr == A_LEN) && (bus_wdata[4:0] == LEN_KEY)
                    && (len_field != '0);
        kick_o    = bus_wr && (bus_addr == A_KICK) && (bus_wdata == KICK_CODE);
        swrst_o   = bus_wr && (bus_addr == A_SWRST) && (bus_wdata == SWRST_CODE);
        mode_wr   = '{two_stage: bus_wdata[6], rearm: bus_wdata[4], irq_en: bus_wdata[3],
                      rst_en: bus_wdata[2], pol_hi: bus_wdata[1], en: bus_wdata[0]};
        en_start  = mode_ok && bus_wdata[0] && !mode_q.en;
    end

    // Purpose: restart strobe and the count the countdown restarts from.
    always_comb begin
        reload_o     = kick_o || len_ok || en_start;
        reload_val_o = len_ok ? len_field : len_q;
    end

    // Purpose: mode storage; a keyed write wins over an expiry-driven disable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else if (mode_ok)
            mode_q <= mode_wr;
        else if (clr_en_i)
            mode_q.en <= 1'b0;
    end

    // Purpose: length storage, power-on value is the longest timeout.
    always_ff @(posedge clk) begin
        if (!rst_n)
            len_q <= LEN_W'(DEF_UNITS);
        else if (len_ok)
            len_q <= len_field;
    end

    // Purpose: read mux, key bits always read as zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_MODE)
            bus_rdata = {25'd0, mode_q.two_stage, 1'b0, mode_q.rearm, mode_q.irq_en,
                         mode_q.rst_en, mode_q.pol_hi, mode_q.en};
        else if (bus_addr == A_LEN)
            bus_rdata[LEN_LSB +: LEN_W] = len_q;
    end

    assign mode_o = mode_q;
    assign len_o  = len_q;
endmodule

// File: rtl/kwdt_counter.sv
// Countdown: a tick prescaler of UNIT_TICKS feeding a unit down-counter.
// Emits a one-cycle expiry pulse and restarts itself from the stored length.
module kwdt_counter #(
    parameter int LEN_W      = 11,
    parameter int UNIT_TICKS = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             reload_i,
    input  logic [LEN_W-1:0] reload_val_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             expire_o
);
    localparam int PRE_W = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(UNIT_TICKS - 1);

    logic [PRE_W-1:0] pre_q;
    logic [LEN_W-1:0] units_q;

    // Purpose: prescale ticks into units and count units down to expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q    <= '0;
            units_q  <= '0;
            expire_o <= 1'b0;
        end else begin
            expire_o <= 1'b0;
            if (reload_i) begin
                pre_q   <= '0;
                units_q <= reload_val_i;
            end else if (run_i && tick_i) begin
                if (pre_q == PRE_LAST) begin
                    pre_q <= '0;
                    if (units_q <= LEN_W'(1)) begin
                        expire_o <= 1'b1;
                        units_q  <= len_i;
                    end else begin
                        units_q <= units_q - 1'b1;
                    end
                end else begin
                    pre_q <= pre_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/kwdt_response.sv
// Expiry response: interrupt, two-stage escalation and the fixed-length reset pulse.
// Assumes the expiry pulse is one cycle wide.
module kwdt_response
    import kwdt_pkg::*;
#(
    parameter int RST_CYC = 16
) (
    input  logic  clk,
    input  logic  rst_n,
    input  mode_t mode_i,
    input  logic  expire_i,
    input  logic  kick_i,
    input  logic  swrst_i,
    output logic  rst_act_o,
    output logic  irq_o,
    output logic  clr_en_o
);
    localparam int CW = $clog2(RST_CYC + 1);

    logic [CW-1:0] pulse_q;
    logic          irq_q;
    logic          wd_fire;

    // Purpose: decide whether this expiry escalates to a reset.
    always_comb begin
        wd_fire  = expire_i && mode_i.en && mode_i.rst_en
                   && (!mode_i.irq_en || (mode_i.two_stage && irq_q));
        clr_en_o = wd_fire && !mode_i.rearm;
    end

    // Purpose: reset pulse length counter, retriggered by any reset request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse_q <= '0;
        else if (swrst_i || wd_fire)
            pulse_q <= CW'(RST_CYC);
        else if (pulse_q != '0)
            pulse_q <= pulse_q - 1'b1;
    end

    // Purpose: level interrupt, cleared by kick, disable or escalation.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else if (kick_i || !mode_i.en || wd_fire)
            irq_q <= 1'b0;
        else if (expire_i && mode_i.irq_en)
            irq_q <= 1'b1;
    end

    assign rst_act_o = (pulse_q != '0);
    assign irq_o     = irq_q;
endmodule

// File: rtl/keyed_wdt.sv
// Top: keyed-access watchdog. tick_i is a synchronous strobe from a slow time base.
// Assumes bus writes are one cycle; reads are combinational on bus_addr.
module keyed_wdt
    import kwdt_pkg::*;
#(
    parameter int ADDR_W        = 8,
    parameter int UNIT_TICKS    = 512,
    parameter int UNITS_PER_SEC = 64,
    parameter int MAX_SECONDS   = 31,
    parameter int RST_CYC       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              wdt_rst_o,
    output logic              irq_o
);
    localparam int DEF_UNITS = MAX_SECONDS * UNITS_PER_SEC;
    localparam int LEN_W     = $clog2(DEF_UNITS + 1);

    mode_t            mode_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] reload_val;
    logic             kick;
    logic             swrst;
    logic             reload;
    logic             expire;
    logic             clr_en;
    logic             rst_act;

    kwdt_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEF_UNITS(DEF_UNITS)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clr_en_i(clr_en),
        .mode_o(mode_q), .len_o(len_q), .kick_o(kick), .swrst_o(swrst),
        .reload_o(reload), .reload_val_o(reload_val)
    );

    kwdt_counter #(.LEN_W(LEN_W), .UNIT_TICKS(UNIT_TICKS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_i(mode_q.en), .tick_i(tick_i),
        .reload_i(reload), .reload_val_i(reload_val), .len_i(len_q),
        .expire_o(expire)
    );

    kwdt_response #(.RST_CYC(RST_CYC)) u_resp (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_q), .expire_i(expire),
        .kick_i(kick), .swrst_i(swrst), .rst_act_o(rst_act), .irq_o(irq_o),
        .clr_en_o(clr_en)
    );

    // Purpose: drive the reset pin at the programmed polarity.
    assign wdt_rst_o = rst_act ? mode_q.pol_hi : !mode_q.pol_hi;
endmodule

// File: rtl/keyed_wdt_chk.sv
// Checker for keyed_wdt, attached by bind. Observes bus inputs and internal state.
module keyed_wdt_chk
    import kwdt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input mode_t             mode_q,
    input logic [LEN_W-1:0]  len_q,
    input logic              expire,
    input logic              clr_en,
    input logic              rst_act,
    input logic              irq_o
);
    logic wr_mode_bad, wr_len_bad, wr_kick, wr_swrst;
    assign wr_mode_bad = bus_wr && bus_addr == ADDR_W'(OFS_MODE) && bus_wdata[31:24] != MODE_KEY;
    assign wr_len_bad  = bus_wr && bus_addr == ADDR_W'(OFS_LEN) && bus_wdata[4:0] != LEN_KEY;
    assign wr_kick     = bus_wr && bus_addr == ADDR_W'(OFS_KICK) && bus_wdata == KICK_CODE;
    assign wr_swrst    = bus_wr && bus_addr == ADDR_W'(OFS_SWRST) && bus_wdata == SWRST_CODE;

    a_r2_mode_key_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode_bad && !clr_en) |=> $stable(mode_q));
    a_r3_len_key_guard: assert property (@(posedge clk) disable iff (!rst_n)
        wr_len_bad |=> $stable(len_q));
    a_r4_halt_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q.en && !$past(mode_q.en)) |-> !expire);
    a_r5_kick_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
        wr_kick |=> !irq_o);
    a_r11_swrst_fires: assert property (@(posedge clk) disable iff (!rst_n)
        wr_swrst |=> rst_act);
endmodule

bind keyed_wdt keyed_wdt_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .mode_q(mode_q), .len_q(len_q), .expire(expire),
    .clr_en(clr_en), .rst_act(rst_act), .irq_o(irq_o)
);

// File: tb/keyed_wdt_bench.sv
`timescale 1ns/1ps
module keyed_wdt_bench;
    localparam int UT  = 4;
    localparam int RC  = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_i = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdt_rst_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    keyed_wdt #(.ADDR_W(8), .UNIT_TICKS(UT), .RST_CYC(RC)) u_keyed_wdt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_rst_o(wdt_rst_o), .irq_o(irq_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick_i = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        rd(8'h00, d); check("R1 mode", d, 32'h0);
        rd(8'h04, d); check("R1 length", d, 32'h0000_F800);
        check("R1 rst idle", {31'd0, wdt_rst_o}, 32'd1);
        check("R1 irq idle", {31'd0, irq_o}, 32'd0);
    endtask

    task automatic t_mode_key();
        logic [31:0] d;
        do_reset();
        wr(8'h00, 32'h2100_005E);
        rd(8'h00, d); check("R2 bad key ignored", d, 32'h0);
        wr(8'h00, 32'h22FF_FF5E);
        rd(8'h00, d); check("R2 readback", d, 32'h0000_005E);
    endtask

    task automatic t_len_key();
        logic [31:0] d;
        do_reset();
        wr(8'h04, (32'd5 << 5) | 32'h09);
        rd(8'h04, d); check("R3 bad key ignored", d, 32'h0000_F800);
        wr(8'h04, 32'h08);
        rd(8'h04, d); check("R3 zero count ignored", d, 32'h0000_F800);
        wr(8'h04, (32'd5 << 5) | 32'h08);
        rd(8'h04, d); check("R3 readback", d, 32'h0000_00A0);
    endtask

    task automatic t_expire(bit pol_hi);
        do_reset();
        wr(8'h04, (32'd3 << 5) | 32'h08);
        wr(8'h00, 32'h2200_0005 | (pol_hi ? 32'h2 : 32'h0));
        wait_cyc(11); check("R4 not yet expired", {31'd0, wdt_rst_o}, {31'd0, !pol_hi});
        wait_cyc(3);  check("R7 pulse active level", {31'd0, wdt_rst_o}, {31'd0, pol_hi});
        wait_cyc(7);  check("R7 pulse ended", {31'd0, wdt_rst_o}, {31'd0, !pol_hi});
    endtask

    task automatic t_rearm(bit rearm);
        logic [31:0] d;
        do_reset();
        wr(8'h04, (32'd3 << 5) | 32'h08);
        wr(8'h00, 32'h2200_0005 | (rearm ? 32'h10 : 32'h0));
        wait_cyc(15);
        rd(8'h00, d);
        check(rearm ? "R8 enable kept" : "R8 enable cleared", d & 32'h1, rearm ? 32'h1 : 32'h0);
    endtask

    task automatic t_kick(bit good);
        do_reset();
        wr(8'h04, (32'd3 << 5) | 32'h08);
        wr(8'h00, 32'h2200_0005);
        wait_cyc(8);
        wr(8'h08, good ? 32'h1971 : 32'h1970);
        wait_cyc(5);
        check(good ? "R5 kick delays reset" : "R5 wrong kick ignored",
              {31'd0, wdt_rst_o}, good ? 32'd1 : 32'd0);
        if (good) begin
            wait_cyc(9); check("R5 reset after kick window", {31'd0, wdt_rst_o}, 32'd0);
        end
    endtask

    task automatic t_len_reload();
        do_reset();
        wr(8'h04, (32'd3 << 5) | 32'h08);
        wr(8'h00, 32'h2200_0005);
        wait_cyc(8);
        wr(8'h04, (32'd5 << 5) | 32'h08);
        wait_cyc(15); check("R6 old timeout dropped", {31'd0, wdt_rst_o}, 32'd1);
        wait_cyc(7);  check("R6 new timeout fires", {31'd0, wdt_rst_o}, 32'd0);
    endtask

    task automatic t_tick_gate();
        do_reset();
        wr(8'h04, (32'd2 << 5) | 32'h08);
        tick_i = 1'b0;
        wr(8'h00, 32'h2200_0005);
        wait_cyc(30); check("R4 no tick no count", {31'd0, wdt_rst_o}, 32'd1);
        tick_i = 1'b1;
        wait_cyc(6);  check("R4 counts once ticking", {31'd0, wdt_rst_o}, 32'd1);
        wait_cyc(5);  check("R4 expiry after ticks", {31'd0, wdt_rst_o}, 32'd0);
    endtask

    task automatic t_irq(bit with_rst);
        do_reset();
        wr(8'h04, (32'd2 << 5) | 32'h08);
        wr(8'h00, with_rst ? 32'h2200_000D : 32'h2200_0009);
        wait_cyc(10); check("R9 irq raised", {31'd0, irq_o}, 32'd1);
        wait_cyc(20);
        check("R9 irq held", {31'd0, irq_o}, 32'd1);
        check("R9 no reset without two-stage", {31'd0, wdt_rst_o}, 32'd1);
        wr(8'h08, 32'h1971);
        check("R5 kick clears irq", {31'd0, irq_o}, 32'd0);
    endtask

    task automatic t_two_stage();
        do_reset();
        wr(8'h04, (32'd2 << 5) | 32'h08);
        wr(8'h00, 32'h2200_004D);
        wait_cyc(12);
        check("R10 first stage irq", {31'd0, irq_o}, 32'd1);
        check("R10 first stage no reset", {31'd0, wdt_rst_o}, 32'd1);
        wait_cyc(6);
        check("R10 second stage reset", {31'd0, wdt_rst_o}, 32'd0);
        check("R10 irq cleared", {31'd0, irq_o}, 32'd0);
    endtask

    task automatic t_swrst();
        do_reset();
        wr(8'h14, 32'h1208);
        wait_cyc(2); check("R11 wrong code ignored", {31'd0, wdt_rst_o}, 32'd1);
        wr(8'h14, 32'h1209);
        check("R11 immediate reset", {31'd0, wdt_rst_o}, 32'd0);
        wait_cyc(7); check("R11 pulse ends", {31'd0, wdt_rst_o}, 32'd1);
    endtask

    initial begin
        t_reset();
        t_mode_key();
        t_len_key();
        t_expire(1'b0);
        t_expire(1'b1);
        t_rearm(1'b0);
        t_rearm(1'b1);
        t_kick(1'b1);
        t_kick(1'b0);
        t_len_reload();
        t_tick_gate();
        t_irq(1'b0);
        t_irq(1'b1);
        t_two_stage();
        t_swrst();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog timeout actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule